// File: doc/BRIEF.md
# Shared Address/Data External Bus Port

This block sequences accesses from an internal requester onto a 16-bit port that serves as the external memory bus. The port works in one of four configurations: data-only with an 8-bit or 16-bit data path (demultiplexed), or address followed by data on the same pins with an 8-bit or 16-bit data path (multiplexed). The requester gives one transfer at a time: the address, byte or word size, the direction and the write data. The block then produces address and data phases on the pins, drives per-bit output enables, and returns read data together with a one-cycle completion pulse.

When the data path is 8 bits wide, a word transfer becomes two byte cycles, low byte first, and the two read bytes are merged into one 16-bit result. In the 8-bit demultiplexed configuration the upper eight pins are not used by the bus and are handed to general-purpose I/O inputs of the block. A phase code and the current byte address come out so that strobe and address logic outside the block can follow each cycle.

Top module: `xbus_port`

## Requirements
- R1: While reset is held, pad_oe is all zero, rsp_done is 0, bus_phase is idle (00) and req_ready is 1.
- R2: cfg_mode selects 0 = 8-bit data-only, 1 = 16-bit data-only, 2 = 8-bit address+data, 3 = 16-bit address+data (bit 1 = shared address/data, bit 0 = 16-bit data). The mode is taken on each idle cycle and held unchanged for the whole of an accepted transfer.
- R3: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 1 exactly when bus_phase is idle; req_valid during a transfer starts nothing.
- R4: In modes 2 and 3 every byte cycle starts with one clock of address phase (bus_phase 01) in which all 16 pins are driven with the cycle's address, followed by one clock of data phase (bus_phase 10).
- R5: In a read data phase the data pins are released (pad_oe 0 on them) and pad_in is sampled at the clock edge that ends the phase.
- R6: A word write on a 16-bit data path drives req_wdata on all 16 pins in the data phase; word transfers always use the even address (address bit 0 ignored).
- R7: A byte transfer on a 16-bit data path uses only the lane chosen by address bit 0 (0 = pins 7..0, 1 = pins 15..8): a write drives req_wdata[7:0] on that lane with only its enables set; a read returns that lane's byte in rsp_rdata[7:0] with the upper byte zero.
- R8: On an 8-bit data path a word transfer takes two byte cycles, the first at the even address carrying bits 7..0 and the second at the odd address carrying bits 15..8, both on pins 7..0; a read returns the two bytes merged. A byte transfer on this path uses pins 7..0 and returns the byte zero-extended.
- R9: In modes 0 and 1 no address phase occurs; each byte cycle is a single data phase and bus_addr carries its address.
- R10: In mode 0 pins 15..8 follow gpio_hi_out and gpio_hi_oe at all times, in idle and during transfers.
- R11: In mode 2 pins 15..8 drive address bits 15..8 of the current cycle in both the address and the data phase.
- R12: rsp_done is a one-clock pulse in the cycle after the last data phase, for reads and writes; rsp_rdata is valid in that cycle and keeps its value until the next read finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Bus configuration code (see R2) |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte writes use bits 7..0) |
| req_ready | output | 1 | Block idle, request may be taken |
| rsp_done | output | 1 | Transfer finished (one-clock pulse) |
| rsp_rdata | output | 16 | Read result |
| pad_in | input | 16 | Value seen on the port pins |
| pad_out | output | 16 | Value driven on the port pins |
| pad_oe | output | 16 | Per-pin output enable |
| gpio_hi_out | input | 8 | I/O value for pins 15..8 in mode 0 |
| gpio_hi_oe | input | 8 | I/O enables for pins 15..8 in mode 0 |
| bus_phase | output | 2 | 00 idle, 01 address phase, 10 data phase |
| bus_addr | output | 16 | Address of the current byte cycle |

## Verification
The hardest case to reach from the ports is a configuration change or a fresh request arriving in the middle of a transfer, which must leave the running transfer untouched. The bench sweeps every mode, direction, size and a set of even, odd and extreme addresses, and in each transfer it flips cfg_mode to the opposite code and raises req_valid with a different request in the first busy cycle, then checks every phase of the transfer against the mode it started with. A memory model computed from bus_addr answers reads, so a wrong byte order, lane or address shows up in the merged result.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Width of the port and of one byte lane
    parameter int unsigned XB_W = 16;
    parameter int unsigned XB_B = XB_W / 2;

    // bit 1: shared address/data pins, bit 0: full-width data path
    typedef enum logic [1:0] {
        MODE_DMX8  = 2'd0,
        MODE_DMX16 = 2'd1,
        MODE_MUX8  = 2'd2,
        MODE_MUX16 = 2'd3
    } bus_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic              beat;
        bus_mode_e         mode;
        logic              wr;
        logic              word;
        logic [XB_W-1:0]   addr;
        logic [XB_W-1:0]   wdata;
    } seq_st_t;

    typedef struct packed {
        logic              done;
        logic [XB_W-1:0]   rdata;
    } cap_st_t;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_word,
    input  logic [XB_W-1:0]  req_addr,
    input  logic [XB_W-1:0]  req_wdata,
    output phase_e           phase,
    output logic             beat,
    output bus_mode_e        mode,
    output logic             wr,
    output logic             word,
    output logic [XB_W-1:0]  cur_addr,
    output logic [XB_W-1:0]  wdata,
    output logic             last_data,
    output logic             ready
);

    seq_st_t st_d, st_q;
    logic    two_beat;

    always_comb begin
        st_d      = st_q;
        two_beat  = st_q.word && !st_q.mode[0];
        last_data = (st_q.phase == PH_DATA) && !(two_beat && !st_q.beat);
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.mode = bus_mode_e'(cfg_mode);
                if (req_valid) begin
                    st_d.wr    = req_write;
                    st_d.word  = req_word;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.beat  = 1'b0;
                    st_d.phase = cfg_mode[1] ? PH_ADDR : PH_DATA;
                end
            end
            PH_ADDR: st_d.phase = PH_DATA;
            PH_DATA: begin
                if (last_data) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.beat  = 1'b1;
                    st_d.phase = st_q.mode[1] ? PH_ADDR : PH_DATA;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, beat: 1'b0, mode: MODE_MUX16,
                      wr: 1'b0, word: 1'b0, addr: '0, wdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Word cycles use the even address; the second byte cycle of a narrow word sets bit 0
    assign cur_addr = st_q.word ? {st_q.addr[XB_W-1:1], two_beat & st_q.beat} : st_q.addr;
    assign phase    = st_q.phase;
    assign beat     = st_q.beat;
    assign mode     = st_q.mode;
    assign wr       = st_q.wr;
    assign word     = st_q.word;
    assign wdata    = st_q.wdata;
    assign ready    = (st_q.phase == PH_IDLE);

endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
(
    input  phase_e           phase,
    input  logic             beat,
    input  bus_mode_e        mode,
    input  logic             wr,
    input  logic             word,
    input  logic [XB_W-1:0]  cur_addr,
    input  logic [XB_W-1:0]  wdata,
    input  logic [XB_B-1:0]  gpio_hi_out,
    input  logic [XB_B-1:0]  gpio_hi_oe,
    output logic [XB_W-1:0]  pad_out,
    output logic [XB_W-1:0]  pad_oe
);

    localparam logic [XB_B-1:0] LANE_ON  = '1;
    localparam logic [XB_B-1:0] LANE_OFF = '0;

    logic [XB_B-1:0] wbyte;

    always_comb begin
        pad_out = '0;
        pad_oe  = '0;
        wbyte   = (word && beat) ? wdata[XB_W-1:XB_B] : wdata[XB_B-1:0];

        if (phase == PH_ADDR) begin
            pad_out = cur_addr;
            pad_oe  = '1;
        end else if (phase == PH_DATA && wr) begin
            if (mode[0]) begin
                if (word) begin
                    pad_out = wdata;
                    pad_oe  = '1;
                end else begin
                    pad_out = {wdata[XB_B-1:0], wdata[XB_B-1:0]};
                    pad_oe  = cur_addr[0] ? {LANE_ON, LANE_OFF} : {LANE_OFF, LANE_ON};
                end
            end else begin
                pad_out[XB_B-1:0] = wbyte;
                pad_oe[XB_B-1:0]  = LANE_ON;
            end
        end

        // Upper lane ownership on a narrow data path
        if (mode == MODE_MUX8 && phase != PH_IDLE) begin
            pad_out[XB_W-1:XB_B] = cur_addr[XB_W-1:XB_B];
            pad_oe[XB_W-1:XB_B]  = LANE_ON;
        end else if (mode == MODE_DMX8) begin
            pad_out[XB_W-1:XB_B] = gpio_hi_out;
            pad_oe[XB_W-1:XB_B]  = gpio_hi_oe;
        end
    end

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_data,
    input  logic             last_data,
    input  logic             wr,
    input  logic             word,
    input  logic             beat,
    input  logic             wide,
    input  logic             lane_sel,
    input  logic [XB_W-1:0]  pad_in,
    output logic [XB_W-1:0]  rdata,
    output logic             done
);

    localparam logic [XB_B-1:0] ZB = '0;

    cap_st_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = last_data;
        if (is_data && !wr) begin
            if (wide) begin
                if (word) begin
                    cap_d.rdata = pad_in;
                end else begin
                    cap_d.rdata = {ZB, lane_sel ? pad_in[XB_W-1:XB_B] : pad_in[XB_B-1:0]};
                end
            end else if (word) begin
                if (beat) begin
                    cap_d.rdata[XB_W-1:XB_B] = pad_in[XB_B-1:0];
                end else begin
                    cap_d.rdata[XB_B-1:0] = pad_in[XB_B-1:0];
                end
            end else begin
                cap_d.rdata = {ZB, pad_in[XB_B-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '{done: 1'b0, rdata: '0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata = cap_q.rdata;
    assign done  = cap_q.done;

endmodule

// File: rtl/xbus_port.sv
module xbus_port
    import xbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [XB_W-1:0]   req_addr,
    input  logic [XB_W-1:0]   req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [XB_W-1:0]   rsp_rdata,
    input  logic [XB_W-1:0]   pad_in,
    output logic [XB_W-1:0]   pad_out,
    output logic [XB_W-1:0]   pad_oe,
    input  logic [XB_B-1:0]   gpio_hi_out,
    input  logic [XB_B-1:0]   gpio_hi_oe,
    output logic [1:0]        bus_phase,
    output logic [XB_W-1:0]   bus_addr
);

    phase_e            seq_phase;
    logic              seq_beat;
    bus_mode_e         lat_mode;
    logic              lat_wr;
    logic              seq_word;
    logic [XB_W-1:0]   seq_addr;
    logic [XB_W-1:0]   seq_wdata;
    logic              seq_last;

    xbus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_word  (req_word),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .phase     (seq_phase),
        .beat      (seq_beat),
        .mode      (lat_mode),
        .wr        (lat_wr),
        .word      (seq_word),
        .cur_addr  (seq_addr),
        .wdata     (seq_wdata),
        .last_data (seq_last),
        .ready     (req_ready)
    );

    xbus_drive u_drive (
        .phase       (seq_phase),
        .beat        (seq_beat),
        .mode        (lat_mode),
        .wr          (lat_wr),
        .word        (seq_word),
        .cur_addr    (seq_addr),
        .wdata       (seq_wdata),
        .gpio_hi_out (gpio_hi_out),
        .gpio_hi_oe  (gpio_hi_oe),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe)
    );

    xbus_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_data   (seq_phase == PH_DATA),
        .last_data (seq_last),
        .wr        (lat_wr),
        .word      (seq_word),
        .beat      (seq_beat),
        .wide      (lat_mode[0]),
        .lane_sel  (seq_addr[0]),
        .pad_in    (pad_in),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    assign bus_phase = seq_phase;
    assign bus_addr  = seq_addr;

endmodule

// File: rtl/xbus_port_chk.sv
module xbus_port_chk
    import xbus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_phase,
    input logic [1:0]        lat_mode,
    input logic              lat_wr,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [XB_W-1:0]   pad_out,
    input logic [XB_W-1:0]   pad_oe,
    input logic [XB_W-1:0]   bus_addr,
    input logic [XB_B-1:0]   gpio_hi_out,
    input logic [XB_B-1:0]   gpio_hi_oe
);

    // R4
    addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase == PH_ADDR |=> bus_phase == PH_DATA);

    // R4
    addr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase == PH_ADDR |-> (pad_oe == '1 && pad_out == bus_addr));

    // R9
    demux_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase == PH_ADDR |-> lat_mode[1]);

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == PH_DATA && !lat_wr) |-> pad_oe[XB_B-1:0] == '0);

    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase != PH_IDLE |-> !req_ready);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R12
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(bus_phase) == PH_DATA);

    // R10
    gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_mode == MODE_DMX8 |->
            (pad_oe[XB_W-1:XB_B] == gpio_hi_oe && pad_out[XB_W-1:XB_B] == gpio_hi_out));

endmodule

bind xbus_port xbus_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_phase   (bus_phase),
    .lat_mode    (lat_mode),
    .lat_wr      (lat_wr),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .bus_addr    (bus_addr),
    .gpio_hi_out (gpio_hi_out),
    .gpio_hi_oe  (gpio_hi_oe)
);

// File: tb/xbus_port_tb.sv
module xbus_port_tb;
    import xbus_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd3;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic [15:0] pad_in;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic [7:0]  gpio_hi_out = 8'hC3;
    logic [7:0]  gpio_hi_oe = 8'h3C;
    logic [1:0]  bus_phase;
    logic [15:0] bus_addr;

    logic [1:0]  tb_mode = 2'd3;
    logic [15:0] last_rd = '0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    xbus_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .gpio_hi_out(gpio_hi_out),
        .gpio_hi_oe(gpio_hi_oe), .bus_phase(bus_phase), .bus_addr(bus_addr)
    );

    function automatic logic [7:0] mb(input logic [15:0] x);
        logic [7:0] p;
        p = x[7:0] * 8'd7;
        return p ^ x[15:8] ^ 8'hA5;
    endfunction

    // External memory model: answers from the address on bus_addr
    always_comb begin
        if (tb_mode[0])
            pad_in = {mb({bus_addr[15:1], 1'b1}), mb({bus_addr[15:1], 1'b0})};
        else
            pad_in = {8'hEE, mb(bus_addr)};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_access(input logic [1:0] m, input bit w, input bit wd,
                             input logic [15:0] a, input logic [15:0] wv);
        int          beats;
        int          na;
        int          nd;
        bit          seen_done;
        logic [15:0] ba;
        logic [15:0] eoe;
        logic [15:0] eout;
        logic [15:0] erd;
        beats = (wd && !m[0]) ? 2 : 1;
        na = 0;
        nd = 0;
        seen_done = 1'b0;
        @(negedge clk);
        cfg_mode = m;
        tb_mode = m;
        req_valid = 1'b1; req_write = w; req_word = wd; req_addr = a; req_wdata = wv;
        chk("R3 ready before request", {31'd0, req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        // Disturb: other mode and another request while busy
        cfg_mode = ~m;
        req_write = ~w; req_word = ~wd; req_addr = ~a; req_wdata = ~wv;
        for (int cyc = 0; cyc < 8; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (cyc == 1) req_valid = 1'b0;
            if (rsp_done) begin
                seen_done = 1'b1;
                break;
            end
            chk("R3 not ready while busy", {31'd0, req_ready}, 32'd0);
            ba = wd ? {a[15:1], (m[0] ? 1'b0 : nd[0])} : a;
            if (bus_phase == 2'd1) begin
                na++;
                chk("R4 address phase enables", pad_oe, 16'hFFFF);
                chk("R4 address phase value", pad_out, ba);
            end else if (bus_phase == 2'd2) begin
                chk("R9 data phase address", bus_addr, ba);
                eoe = '0;
                eout = '0;
                if (w) begin
                    if (m[0]) begin
                        if (wd) begin eoe = 16'hFFFF; eout = wv; end
                        else begin
                            eoe = a[0] ? 16'hFF00 : 16'h00FF;
                            eout = {wv[7:0], wv[7:0]};
                        end
                    end else begin
                        eoe = 16'h00FF;
                        eout = {8'h00, (wd && nd == 1) ? wv[15:8] : wv[7:0]};
                    end
                end
                if (m == 2'd2) begin
                    eoe[15:8] = 8'hFF; eout[15:8] = ba[15:8];
                end else if (m == 2'd0) begin
                    eoe[15:8] = gpio_hi_oe; eout[15:8] = gpio_hi_out;
                end
                if (w && m[0]) begin
                    chk(wd ? "R6 word write enables" : "R7 lane write enables", pad_oe, eoe);
                    chk(wd ? "R6 word write data" : "R7 lane write data", pad_out & eoe, eout & eoe);
                end else if (w) begin
                    chk("R8 narrow write enables", pad_oe, eoe);
                    chk("R8 narrow write data", pad_out & eoe, eout & eoe);
                end else begin
                    chk("R5 read release", pad_oe, eoe);
                    chk("R11 upper lane during read", pad_out & eoe, eout & eoe);
                end
                nd++;
            end else begin
                chk("R3 idle while transfer pending", {30'd0, bus_phase}, 32'd2);
            end
        end
        cfg_mode = m;
        chk("R12 done pulse seen", {31'd0, seen_done}, 32'd1);
        chk("R2 address phase count", na, m[1] ? beats : 0);
        chk("R8 byte cycle count", nd, beats);
        if (!w) begin
            erd = wd ? {mb({a[15:1], 1'b1}), mb({a[15:1], 1'b0})} : {8'h00, mb(a)};
            chk(m[0] ? "R7 read result" : "R8 read result", rsp_rdata, erd);
            last_rd = erd;
        end else begin
            chk("R12 read result held over write", rsp_rdata, last_rd);
        end
        @(negedge clk);
        chk("R12 done is one cycle", {31'd0, rsp_done}, 32'd0);
        chk("R3 no access from busy request", {30'd0, bus_phase}, 32'd0);
    endtask

    initial begin
        logic [15:0] addrs [6];
        addrs[0] = 16'h0000; addrs[1] = 16'h0001; addrs[2] = 16'h1234;
        addrs[3] = 16'h8765; addrs[4] = 16'hFFFE; addrs[5] = 16'hFFFF;
        repeat (2) @(negedge clk);
        chk("R1 reset enables", pad_oe, 16'h0000);
        chk("R1 reset done", {31'd0, rsp_done}, 32'd0);
        chk("R1 reset phase", {30'd0, bus_phase}, 32'd0);
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_mode = 2'd0;
        @(negedge clk);
        chk("R10 idle gpio enables", pad_oe, {gpio_hi_oe, 8'h00});
        chk("R10 idle gpio value", pad_out[15:8], gpio_hi_out);
        gpio_hi_oe = 8'hA1; gpio_hi_out = 8'h5E;
        #1;
        chk("R10 gpio follows input", pad_oe, {8'hA1, 8'h00});
        cfg_mode = 2'd3;
        @(negedge clk);
        chk("R2 wide mode frees upper pins", pad_oe, 16'h0000);
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 6; i++)
                for (int k = 0; k < 4; k++) begin
                    gpio_hi_oe = addrs[i][7:0] ^ 8'h0F;
                    gpio_hi_out = addrs[i][15:8] ^ 8'hF0;
                    do_access(m[1:0], k[1], k[0], addrs[i], addrs[i] ^ 16'h3C96);
                end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule